// File: doc/BRIEF.md
# Signed Multiply Execute and Commit Unit

This unit carries out a signed integer multiply for 8-, 16- and 32-bit operand sizes and produces everything needed to commit the result: write enables and data for the accumulator pair (EAX, EDX), write enable and data for a single general register, and the six arithmetic flags. Operands arrive already fetched; the unit sign-extends them by operand size, runs an iterative multiplier that retires two multiplier bits per cycle, and then presents one writeback cycle.

A caller raises `start` with the operands when `ready` is high. The request is taken on that clock edge. `ready` stays low while the multiplier works. In accumulator mode (`acc_mode`=1) `op_a` is the current EAX, and `edx_prev` is the current EDX. The unit merges the product into these registers under partial-register rules: upper halves are preserved for the narrow sizes. In register mode the truncated product goes to the single destination register, and the register file merges it by size. The second operand may be an 8-bit immediate that is sign-extended (`imm8_se`).

Size encoding on `size`: 2'b00 = 8-bit, 2'b01 = 16-bit, 2'b10 (and 2'b11) = 32-bit.

Top module: `smul_commit`

## Requirements
- R1: The product is the signed 64-bit product of `op_a` and `op_b`, each sign-extended from the operand size. In accumulator mode with 32-bit size, `eax_wdata` is product[31:0] and `edx_wdata` is product[63:32], and both write enables are high.
- R2: When `imm8_se`=1, the second operand is `op_b[7:0]` sign-extended, whatever the operand size.
- R3: `flag_c` and `flag_o` are both 1 exactly when the full product differs from the product truncated to the operand size and then sign-extended, and both are 0 otherwise.
- R4: `flag_a` is 0 after every multiply.
- R5: `flag_z` and `flag_s` come from the low byte, halfword or word of the product, chosen by operand size. `flag_p` is 1 when product[7:0] holds an even number of ones.
- R6: In accumulator mode with 8-bit size, `eax_wdata` is {op_a[31:16], product[15:0]} and `edx_we` is 0.
- R7: In accumulator mode with 16-bit size, `eax_wdata` is {op_a[31:16], product[15:0]} and `edx_wdata` is {edx_prev[31:16], product[31:16]}.
- R8: In register mode, `reg_we`=1 and `reg_wdata` is product[31:0], while `eax_we` and `edx_we` are 0.
- R9: A request is accepted only on a clock edge where `start` and `ready` are both high. `start` while `ready` is low has no effect. `wb_valid` rises exactly 17 clock edges after the accepting edge and lasts exactly one cycle.
- R10: No result is produced while the multiplier is busy. Each writeback follows the multiplier's completion, and each accepted request produces exactly one writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a multiply |
| ready | output | 1 | Unit can accept a request this cycle |
| size | input | 2 | Operand size: 00 byte, 01 halfword, 10/11 word |
| acc_mode | input | 1 | 1: write EAX/EDX pair, 0: write single register |
| imm8_se | input | 1 | Second operand is sign-extended op_b[7:0] |
| op_a | input | 32 | First operand (current EAX in accumulator mode) |
| op_b | input | 32 | Second operand |
| edx_prev | input | 32 | Current EDX value for merging |
| wb_valid | output | 1 | Writeback cycle; flags are valid |
| eax_we | output | 1 | EAX write enable |
| eax_wdata | output | 32 | EAX write data |
| edx_we | output | 1 | EDX write enable |
| edx_wdata | output | 32 | EDX write data |
| reg_we | output | 1 | Destination register write enable |
| reg_wdata | output | 32 | Destination register write data |
| flag_c | output | 1 | Carry flag |
| flag_p | output | 1 | Parity flag |
| flag_a | output | 1 | Auxiliary carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_o | output | 1 | Overflow flag |

## Verification
The assertions check several properties on every cycle. The multiplier never signals completion while busy. A writeback always follows a completion and lasts one cycle. EDX is never written for a byte multiply in accumulator mode. The EAX upper half is preserved for narrow sizes. The numeric correctness of products, the overflow and flag values across signs and sizes, the sign-extended immediate, the exact latency, and the case where a new request is accepted in the same cycle as the previous writeback can only be shown by the bench's scenarios, which compare each writeback against an independently computed expectation.

// File: rtl/smul_pkg.sv
// Package smul_pkg
// Shared types and helpers for the signed multiply unit.
// Assumes a 32-bit architectural word.
package smul_pkg;

    localparam int WORD = 32;

    typedef enum logic [1:0] {
        SZ_B = 2'b00,
        SZ_H = 2'b01,
        SZ_W = 2'b10,
        SZ_X = 2'b11
    } opsz_e;

    // Context kept from acceptance until writeback.
    typedef struct packed {
        opsz_e       size;
        logic        acc;
        logic [15:0] a_hi;
        logic [15:0] d_hi;
    } ctx_t;

    // Sign-extend the low bits of v selected by size to a full word.
    function automatic logic [WORD-1:0] sext_size(input logic [WORD-1:0] v, input opsz_e sz);
        logic [WORD-1:0] r;
        case (sz)
            SZ_B:    r = {{(WORD-8){v[7]}}, v[7:0]};
            SZ_H:    r = {{(WORD-16){v[15]}}, v[15:0]};
            default: r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/smul_iter.sv
// Module smul_iter
// Iterative signed multiplier. It takes magnitudes of both operands,
// accumulates BPS multiplier bits per cycle and applies the sign at the end.
// Assumes W is a multiple of BPS. Busy for W/BPS cycles after load;
// done pulses for one cycle on the edge that retires the last step.
module smul_iter #(
    parameter int W   = 32,
    parameter int BPS = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [W-1:0]   a_sx,
    input  logic [W-1:0]   b_sx,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] prod
);
    localparam int STEPS = W / BPS;
    localparam int CW    = $clog2(STEPS + 1);
    localparam int PW    = 2 * W;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    logic [PW-1:0] mcand;
    logic [W-1:0]  mplier;
    logic [PW-1:0] acc;
    logic          neg;
    logic [CW-1:0] cnt;
    logic [PW-1:0] partial;
    logic [BPS-1:0][PW-1:0] pp;

    // One shifted copy of the multiplicand per retired multiplier bit.
    genvar g;
    generate
        for (g = 0; g < BPS; g++) begin : g_pp
            assign pp[g] = mplier[g] ? (mcand << g) : '0;
        end
    endgenerate

    // Sum the partial products for this step.
    always_comb begin
        partial = '0;
        for (int j = 0; j < BPS; j++) begin
            partial = partial + pp[j];
        end
    end

    // Load magnitudes on request, then shift-and-add until the count ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            neg    <= 1'b0;
            cnt    <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else if (load) begin
            mcand  <= {{W{1'b0}}, (a_sx[W-1] ? (~a_sx + 1'b1) : a_sx)};
            mplier <= b_sx[W-1] ? (~b_sx + 1'b1) : b_sx;
            acc    <= '0;
            neg    <= a_sx[W-1] ^ b_sx[W-1];
            cnt    <= '0;
            busy   <= 1'b1;
            done   <= 1'b0;
        end else if (busy) begin
            acc    <= acc + partial;
            mcand  <= mcand << BPS;
            mplier <= mplier >> BPS;
            cnt    <= cnt + 1'b1;
            busy   <= (cnt != LAST);
            done   <= (cnt == LAST);
        end else begin
            done   <= 1'b0;
        end
    end

    // Apply the product sign to the accumulated magnitude.
    always_comb begin
        prod = neg ? (~acc + 1'b1) : acc;
    end

    AST_NO_RESULT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R10
    AST_BUSY_UNTIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != LAST) |=> busy); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> !done); // R10

endmodule

// File: rtl/smul_flags.sv
// Module smul_flags
// Combinational overflow and result-flag logic for a signed product.
// Assumes prod is the full 64-bit signed product and size is the
// operand size that also sets the destination width.
module smul_flags
    import smul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2*W-1:0] prod,
    input  opsz_e          size,
    output logic           ovf,
    output logic           zf,
    output logic           sf,
    output logic           pf
);
    localparam int PW = 2 * W;

    logic [PW-1:0] trunc_sx;

    // Truncate to the destination width and sign-extend back.
    always_comb begin
        case (size)
            SZ_B:    trunc_sx = {{(PW-8){prod[7]}}, prod[7:0]};
            SZ_H:    trunc_sx = {{(PW-16){prod[15]}}, prod[15:0]};
            default: trunc_sx = {{(PW-W){prod[W-1]}}, prod[W-1:0]};
        endcase
    end

    // Overflow, zero, sign and parity of the sized result.
    always_comb begin
        ovf = (trunc_sx != prod);
        case (size)
            SZ_B:    begin zf = (prod[7:0] == '0);  sf = prod[7];   end
            SZ_H:    begin zf = (prod[15:0] == '0); sf = prod[15];  end
            default: begin zf = (prod[W-1:0] == '0); sf = prod[W-1]; end
        endcase
        pf = ~^prod[7:0];
    end

endmodule

// File: rtl/smul_commit.sv
// Module smul_commit
// Signed multiply execute and writeback. It accepts a request when idle,
// sign-extends the operands, runs smul_iter, then issues one writeback
// cycle with partial-register merging and flag results.
// Assumes op_a is the current EAX in accumulator mode.
module smul_commit
    import smul_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int BPS  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            ready,
    input  logic [1:0]      size,
    input  logic            acc_mode,
    input  logic            imm8_se,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] edx_prev,
    output logic            wb_valid,
    output logic            eax_we,
    output logic [XLEN-1:0] eax_wdata,
    output logic            edx_we,
    output logic [XLEN-1:0] edx_wdata,
    output logic            reg_we,
    output logic [XLEN-1:0] reg_wdata,
    output logic            flag_c,
    output logic            flag_p,
    output logic            flag_a,
    output logic            flag_z,
    output logic            flag_s,
    output logic            flag_o
);
    localparam int PW   = 2 * XLEN;
    localparam int HALF = XLEN / 2;

    logic            mul_busy;
    logic            mul_done;
    logic [PW-1:0]   prod;
    logic            accept;
    logic [XLEN-1:0] a_sx;
    logic [XLEN-1:0] b_sx;
    ctx_t            ctx;
    logic            ovf, zf, sf, pf;
    opsz_e           req_size;

    assign req_size = opsz_e'(size);
    assign ready    = ~mul_busy;
    assign accept   = start & ready;

    // Sign-extend operands by size; the immediate form uses 8 bits.
    always_comb begin
        a_sx = sext_size(op_a, req_size);
        b_sx = imm8_se ? sext_size(op_b, SZ_B) : sext_size(op_b, req_size);
    end

    smul_iter #(.W(XLEN), .BPS(BPS)) u_iter (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .a_sx (a_sx),
        .b_sx (b_sx),
        .busy (mul_busy),
        .done (mul_done),
        .prod (prod)
    );

    smul_flags #(.W(XLEN)) u_flags (
        .prod(prod),
        .size(ctx.size),
        .ovf (ovf),
        .zf  (zf),
        .sf  (sf),
        .pf  (pf)
    );

    // Capture the request context needed at writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx <= '0;
        end else if (accept) begin
            ctx.size <= (req_size == SZ_X) ? SZ_W : req_size;
            ctx.acc  <= acc_mode;
            ctx.a_hi <= op_a[XLEN-1:HALF];
            ctx.d_hi <= edx_prev[XLEN-1:HALF];
        end
    end

    // Build the one-cycle writeback with partial-register merging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid  <= 1'b0;
            eax_we    <= 1'b0;
            edx_we    <= 1'b0;
            reg_we    <= 1'b0;
            eax_wdata <= '0;
            edx_wdata <= '0;
            reg_wdata <= '0;
            flag_c    <= 1'b0;
            flag_p    <= 1'b0;
            flag_a    <= 1'b0;
            flag_z    <= 1'b0;
            flag_s    <= 1'b0;
            flag_o    <= 1'b0;
        end else if (mul_done) begin
            wb_valid  <= 1'b1;
            eax_we    <= ctx.acc;
            edx_we    <= ctx.acc && (ctx.size != SZ_B);
            reg_we    <= ~ctx.acc;
            eax_wdata <= (ctx.size == SZ_W) ? prod[XLEN-1:0] : {ctx.a_hi, prod[HALF-1:0]};
            edx_wdata <= (ctx.size == SZ_H) ? {ctx.d_hi, prod[XLEN-1:HALF]} : prod[PW-1:XLEN];
            reg_wdata <= prod[XLEN-1:0];
            flag_c    <= ovf;
            flag_o    <= ovf;
            flag_a    <= 1'b0;
            flag_z    <= zf;
            flag_s    <= sf;
            flag_p    <= pf;
        end else begin
            wb_valid  <= 1'b0;
            eax_we    <= 1'b0;
            edx_we    <= 1'b0;
            reg_we    <= 1'b0;
        end
    end

    AST_ONE_CYCLE_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid); // R9
    AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(mul_done)); // R10
    AST_EDX_UNTOUCHED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(ctx.acc) && $past(ctx.size) == SZ_B) |-> !edx_we); // R6
    AST_EAX_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (eax_we && $past(ctx.size) != SZ_W) |-> (eax_wdata[XLEN-1:HALF] == $past(ctx.a_hi))); // R7
    AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (!eax_we && !edx_we)); // R8

endmodule

// File: tb/tb_smul_commit.sv
// Scoreboard bench for smul_commit: a driver task queues expected
// writebacks, a monitor compares them as wb_valid appears.
module tb_smul_commit;

    localparam int LAT = 18; // driver negedge to monitor negedge (17 edges after accept)

    typedef struct {
        logic        eax_we, edx_we, reg_we;
        logic [31:0] eax_d, edx_d, reg_d;
        logic        c, p, z, s, o;
        int          t0;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic        ready;
    logic [1:0]  size = 0;
    logic        acc_mode = 0;
    logic        imm8_se = 0;
    logic [31:0] op_a = 0, op_b = 0, edx_prev = 0;
    logic        wb_valid, eax_we, edx_we, reg_we;
    logic [31:0] eax_wdata, edx_wdata, reg_wdata;
    logic        flag_c, flag_p, flag_a, flag_z, flag_s, flag_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pending = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    smul_commit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .size(size), .acc_mode(acc_mode), .imm8_se(imm8_se),
        .op_a(op_a), .op_b(op_b), .edx_prev(edx_prev),
        .wb_valid(wb_valid), .eax_we(eax_we), .eax_wdata(eax_wdata),
        .edx_we(edx_we), .edx_wdata(edx_wdata), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .flag_c(flag_c), .flag_p(flag_p),
        .flag_a(flag_a), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o)
    );

    initial forever @(posedge clk) cyc++;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [31:0] v, input logic [1:0] sz);
        case (sz)
            2'b00:   return {{24{v[7]}}, v[7:0]};
            2'b01:   return {{16{v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

    // Driver: wait for ready, present one request, queue its expectation.
    task automatic issue(input string tag, input logic [1:0] sz, input logic acc,
                         input logic imm, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] dprev);
        exp_t e;
        logic [31:0] sa, sb;
        longint p, t;
        @(negedge clk);
        while (!ready) @(negedge clk);
        size = sz; acc_mode = acc; imm8_se = imm;
        op_a = a; op_b = b; edx_prev = dprev; start = 1;
        sa = sx(a, sz);
        sb = imm ? sx(b, 2'b00) : sx(b, sz);
        p = longint'(signed'(sa)) * longint'(signed'(sb));
        case (sz)
            2'b00:   t = longint'(byte'(p));
            2'b01:   t = longint'(shortint'(p));
            default: t = longint'(int'(p));
        endcase
        e.o = (t != p);
        e.c = e.o;
        e.p = ~^p[7:0];
        case (sz)
            2'b00:   begin e.z = (p[7:0] == 0);  e.s = p[7];  end
            2'b01:   begin e.z = (p[15:0] == 0); e.s = p[15]; end
            default: begin e.z = (p[31:0] == 0); e.s = p[31]; end
        endcase
        e.eax_we = acc;
        e.edx_we = acc && (sz != 2'b00);
        e.reg_we = !acc;
        e.eax_d  = (sz[1]) ? p[31:0] : {a[31:16], p[15:0]};
        e.edx_d  = (sz == 2'b01) ? {dprev[31:16], p[31:16]} : p[63:32];
        e.reg_d  = p[31:0];
        e.t0     = cyc;
        e.tag    = tag;
        q.push_back(e);
        pending++;
        @(negedge clk);
        start = 0;
    endtask

    // Monitor: compare every writeback against the oldest expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && wb_valid) begin
                if (q.size() == 0) begin
                    chk("R10", "unexpected writeback", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    pending--;
                    chk("R9", {e.tag, " latency"}, 32'(cyc - e.t0), 32'(LAT));
                    chk("R8", {e.tag, " we"}, {29'd0, eax_we, edx_we, reg_we},
                        {29'd0, e.eax_we, e.edx_we, e.reg_we});
                    if (e.eax_we) chk("R1", {e.tag, " eax"}, eax_wdata, e.eax_d);
                    if (e.edx_we) chk("R7", {e.tag, " edx"}, edx_wdata, e.edx_d);
                    if (e.reg_we) chk("R2", {e.tag, " reg"}, reg_wdata, e.reg_d);
                    chk("R3", {e.tag, " cf/of"}, {30'd0, flag_c, flag_o}, {30'd0, e.c, e.o});
                    chk("R4", {e.tag, " af"}, {31'd0, flag_a}, 32'd0);
                    chk("R5", {e.tag, " zf/sf/pf"}, {29'd0, flag_z, flag_s, flag_p},
                        {29'd0, e.z, e.s, e.p});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "reset ready", {31'd0, ready}, 32'd1);
        chk("R10", "reset wb_valid", {31'd0, wb_valid}, 32'd0);
        rst_n = 1;

        // R1 32-bit accumulator pair, mixed signs
        issue("R1 w neg", 2'b10, 1'b1, 1'b0, 32'hFFFF_FFFD, 32'h0000_0007, 32'h1234_5678);
        issue("R1 w big", 2'b10, 1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000, 32'h0);
        issue("R3 w fits", 2'b10, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_0100, 32'hDEAD_BEEF);
        // R6 8-bit accumulator
        issue("R6 b ovf", 2'b00, 1'b1, 1'b0, 32'hAAAA_BB7F, 32'h5555_5502, 32'hCAFE_F00D);
        issue("R6 b fits", 2'b00, 1'b1, 1'b0, 32'h1234_56FE, 32'h0000_0003, 32'hCAFE_F00D);
        issue("R5 b zero", 2'b00, 1'b1, 1'b0, 32'h7777_7700, 32'h0000_0085, 32'h0);
        // R7 16-bit accumulator
        issue("R7 h ovf", 2'b01, 1'b1, 1'b0, 32'hABCD_8001, 32'h0000_7FFF, 32'h9876_5432);
        issue("R7 h fits", 2'b01, 1'b1, 1'b0, 32'hABCD_FFFF, 32'hFFFF_FFFF, 32'h9876_5432);
        // R8 register mode
        issue("R8 w", 2'b10, 1'b0, 1'b0, 32'h0001_0000, 32'h0001_0000, 32'h0);
        issue("R8 h", 2'b01, 1'b0, 1'b0, 32'h0000_0100, 32'h0000_FF00, 32'h0);
        // R2 sign-extended immediate
        issue("R2 imm neg", 2'b10, 1'b0, 1'b1, 32'h0000_0064, 32'h1234_56F6, 32'h0);
        issue("R2 imm h", 2'b01, 1'b0, 1'b1, 32'h0000_7000, 32'h0000_0081, 32'h0);

        // R9: start held while busy must be ignored
        issue("R9 base", 2'b10, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0009, 32'h0);
        @(negedge clk);
        op_a = 32'h1111_1111; op_b = 32'h2222_2222; start = 1;
        while (!ready) @(negedge clk);
        start = 0;
        repeat (LAT + 4) @(negedge clk);
        chk("R9", "ignored start leaves no queue item", 32'(pending), 32'd0);
        chk("R10", "no extra writeback", 32'(q.size()), 32'd0);

        repeat (LAT + 4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule